// File: doc/BRIEF.md
# External Interrupt Request Controller

This block prepares one active-low external interrupt pin for use by a CPU. The pin passes through a two-flop synchronizer. The conditioned signal then drives either a level-sensitive request or a falling-edge latch. An 8-bit control register on a simple write/read-back bus selects the sensing style and connects the pin to the interrupt logic or isolates it from it.

The sensing-style bit is protected in normal and emulation operation. Only the first register write after reset can set it, and every write in those modes, whatever its data, closes it. In special operation it stays writable any number of times. The enable bit is writable at any time in every mode.

A latched edge stays pending until reset or until the CPU returns a one-cycle service acknowledge. A new falling edge in the acknowledge cycle wins, and the latch stays set. While the pin is disabled, the latch is held clear.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset the control register reads 0x40 (bit 6 enable = 1, bit 7 edge select = 0) and `irq_req` is 0.
- R2: Register bits 5..0 always read 0, whatever value is written to them.
- R3: With edge select 0 and enable 1, `irq_req` is 1 while the synchronized pin is low and 0 while it is high.
- R4: With edge select 1 and enable 1, a falling edge on the pin sets a latched request. The latched request holds after the pin returns high.
- R5: A one-cycle `svc_ack` clears the latched request. If a falling edge is detected in the same cycle, the latch stays set.
- R6: With `special_mode` = 0, bit 7 is written only by the first register write after reset. Any such write, whatever its data, blocks later bit-7 writes until reset.
- R7: With `special_mode` = 1, bit 7 takes the written value on every write, and such writes do not block bit 7.
- R8: Bit 6 (enable) takes the written value on every write in either mode.
- R9: With enable 0, `irq_req` is 0, the edge latch is held clear, and edges seen while disabled are not pending after re-enabling.
- R10: A pin change reaches `irq_req` in level mode two clock edges after it is applied, and not after one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| special_mode | input | 1 | 1 = special operation, 0 = normal/emulation; sampled on each write |
| reg_wr | input | 1 | Register write strobe, one write per high cycle |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read-back: {edge select, enable, 6'b0} |
| svc_ack | input | 1 | One-cycle interrupt-serviced pulse |
| irq_req | output | 1 | Interrupt request to the CPU, active high |

## Verification
A wrong lock flag appears at the read-back port on the clock edge after the next write: bit 7 either moves when it should hold or holds when it should move. A wrong edge latch appears on `irq_req` one cycle after the bad update. That includes a pending request that survives an acknowledge, that is lost to an acknowledge that collides with a new edge, or that is captured while the pin is disabled. A synchronizer with the wrong depth shifts the level response by a whole cycle. The bench samples at exactly two edges to expose that.

// File: rtl/xirq_pkg.sv
// Package: shared constants for the external interrupt request controller.
// Assumes an 8-bit control register with edge select at bit 7 and enable at bit 6.
package xirq_pkg;
    localparam int REG_W    = 8;
    localparam int EDGE_BIT = 7;
    localparam int EN_BIT   = 6;
    localparam logic EDGE_RST = 1'b0;
    localparam logic EN_RST   = 1'b1;
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/xirq_sync.sv
// Module: pin synchronizer. Carries an asynchronous pin through STAGES flops and
// keeps one extra flop of history so a downstream falling-edge detector can compare.
// Assumes an idle-high (active-low) pin, so all stages reset to 1.
module xirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic sync_o,
    output logic prev_o
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Purpose: shift the pin into the synchronizer chain; reset to the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[CHAIN_W-2:0], pin_i};
    end

    assign sync_o = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/xirq_cfg.sv
// Module: control register. Holds the edge-select and enable bits. Edge select is
// guarded by a write-once flag that any write outside special mode sets.
// Assumes one write per cycle that reg_wr is high; special_mode is sampled with it.
module xirq_cfg
    import xirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic special_i,
    input  logic edge_wr_i,
    input  logic en_wr_i,
    output logic edge_o,
    output logic en_o
);
    logic locked_q;

    // Purpose: update enable always; update edge select only when unlocked or special.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_o   <= EDGE_RST;
            en_o     <= EN_RST;
            locked_q <= 1'b0;
        end else if (wr_i) begin
            en_o <= en_wr_i;
            if (special_i || !locked_q) edge_o <= edge_wr_i;
            if (!special_i) locked_q <= 1'b1;
        end
    end

    p_edge_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && wr_i && !special_i) |=> $stable(edge_o));
    p_edge_special_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && special_i) |=> (edge_o == $past(edge_wr_i)));
    p_enable_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (en_o == $past(en_wr_i)));
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> ($stable(edge_o) && $stable(en_o)));
endmodule

// File: rtl/xirq_edge_latch.sv
// Module: falling-edge latch. Sets on a detected falling edge in edge mode. Clears on a
// service acknowledge unless a new edge arrives in that cycle, and is held clear while disabled.
// Assumes fall_i is a one-cycle pulse derived from synchronized samples.
module xirq_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic edge_mode_i,
    input  logic fall_i,
    input  logic ack_i,
    output logic pend_o
);
    // Purpose: capture edges with priority over acknowledge; force clear when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                    pend_o <= 1'b0;
        else if (!en_i)                pend_o <= 1'b0;
        else if (fall_i && edge_mode_i) pend_o <= 1'b1;
        else if (ack_i)                pend_o <= 1'b0;
    end

    p_clear_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pend_o);
    p_hold_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && en_i && !ack_i) |=> pend_o);
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && en_i && ack_i && !fall_i) |=> !pend_o);
    p_edge_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && edge_mode_i && fall_i) |=> pend_o);
endmodule

// File: rtl/xirq_ctrl.sv
// Module: external interrupt request controller top. Synchronizes the active-low pin,
// detects falling edges, and forms the request from level or latch, gated by enable.
// Assumes reg_rdata is continuously valid; there is no read strobe.
module xirq_ctrl
    import xirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_pin_n,
    input  logic             special_mode,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             svc_ack,
    output logic             irq_req
);
    logic pin_s, pin_prev, fall, edge_sel, enable, pending;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata[EN_BIT-1:0];

    xirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(irq_pin_n),
        .sync_o(pin_s), .prev_o(pin_prev)
    );

    xirq_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .special_i(special_mode),
        .edge_wr_i(reg_wdata[EDGE_BIT]), .en_wr_i(reg_wdata[EN_BIT]),
        .edge_o(edge_sel), .en_o(enable)
    );

    // Purpose: a falling edge is a high previous sample followed by a low current one.
    assign fall = pin_prev & ~pin_s;

    xirq_edge_latch u_latch (
        .clk(clk), .rst_n(rst_n), .en_i(enable), .edge_mode_i(edge_sel),
        .fall_i(fall), .ack_i(svc_ack), .pend_o(pending)
    );

    // Purpose: choose the request source by sensing style and gate it with enable.
    always_comb begin
        irq_req = enable & (edge_sel ? pending : ~pin_s);
    end

    // Purpose: assemble read-back; unimplemented bits read zero.
    always_comb begin
        reg_rdata           = '0;
        reg_rdata[EDGE_BIT] = edge_sel;
        reg_rdata[EN_BIT]   = enable;
    end

    p_zero_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[EN_BIT-1:0] == '0);
    p_req_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[EN_BIT] |-> !irq_req);
    p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[EN_BIT] && !reg_rdata[EDGE_BIT]) |-> (irq_req == !pin_s));
    p_reset_state_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (reg_rdata == 8'h40 && !irq_req));
endmodule

// File: tb/xirq_ctrl_bench.sv
module xirq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_pin_n = 1'b1;
    logic       special_mode = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       svc_ack = 1'b0;
    logic       irq_req;
    int         n_run = 0;
    int         n_fail = 0;

    always #10 clk = ~clk;

    xirq_ctrl u_xirq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .special_mode(special_mode),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .svc_ack(svc_ack), .irq_req(irq_req)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_pin_n = 1'b1; reg_wr = 1'b0; svc_ack = 1'b0;
        edges(2);
        rst_n = 1'b1;
        edges(3);
    endtask

    task automatic wr(input logic [7:0] d, input logic sp);
        reg_wr = 1'b1; reg_wdata = d; special_mode = sp;
        edges(1);
        reg_wr = 1'b0; special_mode = 1'b0;
    endtask

    task automatic ack();
        svc_ack = 1'b1;
        edges(1);
        svc_ack = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(reg_rdata, 8'h40, "R1 reset read-back");
        chk({7'd0, irq_req}, 8'h00, "R1 reset request");
    endtask

    task automatic t_level();
        do_reset();
        irq_pin_n = 1'b0;
        edges(1);
        chk({7'd0, irq_req}, 8'h00, "R10 not after one edge");
        edges(1);
        chk({7'd0, irq_req}, 8'h01, "R10 R3 level asserted after two edges");
        irq_pin_n = 1'b1;
        edges(2);
        chk({7'd0, irq_req}, 8'h00, "R3 level released");
    endtask

    task automatic t_write_once();
        do_reset();
        wr(8'hC0, 1'b0);
        chk(reg_rdata, 8'hC0, "R6 first normal write");
        wr(8'h40, 1'b0);
        chk(reg_rdata, 8'hC0, "R6 second normal write ignored");
        wr(8'h80, 1'b0);
        chk(reg_rdata, 8'h80, "R8 enable cleared in normal mode");
        wr(8'h40, 1'b0);
        chk(reg_rdata, 8'hC0, "R8 enable set, R6 edge still held");
    endtask

    task automatic t_special();
        do_reset();
        wr(8'h80, 1'b1);
        chk(reg_rdata, 8'h80, "R7 special write 1");
        wr(8'h40, 1'b1);
        chk(reg_rdata, 8'h40, "R7 special write 2");
        wr(8'hC0, 1'b1);
        chk(reg_rdata, 8'hC0, "R7 special write 3");
        wr(8'h40, 1'b0);
        chk(reg_rdata, 8'h40, "R6 first normal write after special");
        wr(8'hC0, 1'b0);
        chk(reg_rdata, 8'h40, "R6 locked after normal write");
    endtask

    task automatic t_edge();
        do_reset();
        wr(8'hC0, 1'b0);
        irq_pin_n = 1'b0;
        edges(3);
        chk({7'd0, irq_req}, 8'h01, "R4 edge captured");
        irq_pin_n = 1'b1;
        edges(4);
        chk({7'd0, irq_req}, 8'h01, "R4 latch holds after pin high");
        ack();
        chk({7'd0, irq_req}, 8'h00, "R5 acknowledge clears");
    endtask

    task automatic t_collide();
        do_reset();
        wr(8'hC0, 1'b0);
        irq_pin_n = 1'b0;
        edges(3);
        irq_pin_n = 1'b1;
        edges(3);
        irq_pin_n = 1'b0;
        edges(2);
        ack();
        chk({7'd0, irq_req}, 8'h01, "R5 new edge beats acknowledge");
        irq_pin_n = 1'b1;
        edges(3);
        ack();
        chk({7'd0, irq_req}, 8'h00, "R5 later acknowledge clears");
    endtask

    task automatic t_disable();
        do_reset();
        wr(8'h80, 1'b0);
        irq_pin_n = 1'b0;
        edges(4);
        chk({7'd0, irq_req}, 8'h00, "R9 no request while disabled");
        irq_pin_n = 1'b1;
        edges(3);
        wr(8'hC0, 1'b0);
        edges(1);
        chk({7'd0, irq_req}, 8'h00, "R9 edge while disabled not pending");
        do_reset();
        wr(8'h00, 1'b0);
        irq_pin_n = 1'b0;
        edges(3);
        chk({7'd0, irq_req}, 8'h00, "R9 level gated off");
        irq_pin_n = 1'b1;
    endtask

    task automatic t_unimpl();
        do_reset();
        wr(8'h3F, 1'b1);
        chk(reg_rdata, 8'h00, "R2 low bits read zero");
        wr(8'h7F, 1'b1);
        chk(reg_rdata, 8'h40, "R2 low bits read zero with enable");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_level();
        t_write_once();
        t_special();
        t_edge();
        t_collide();
        t_disable();
        t_unimpl();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule